// File: doc/BRIEF.md
# Trapezoid Edge Staircase Sequencer

This block produces one DAC sample code per clock. The codes trace a repeating trapezoid made of four segments: a high plateau, a falling staircase edge, a low plateau and a rising staircase edge. Each edge always takes sixteen samples, so the edge slope is the same at every output frequency. Slower waveforms come only from longer plateaus. After the DAC, a fixed reconstruction filter smooths the staircase and a comparator picks out the crossing point.

Timing finer than one sample period comes from two mechanisms. A fine-timing index lifts every staircase level by a small amplitude offset. The offset is clamped so that only the end steps of an edge change shape, and this moves the filtered crossing by a fraction of a sample. A 10-bit fractional half-period accumulates from plateau to plateau, and each carry adds one sample to a plateau, so the average period is exact. All settings are taken at the start of each high plateau. While enable is low the output sits at the low code and the fraction accumulator is cleared.

Top module: `trapezoid_edge_gen`

## Requirements
- R1: The segment output follows the order high (1), falling (2), low (3), rising (4) and then high again. Idle is 0. Enabling from idle enters high, and the first high sample appears in the cycle after the clock edge at which enable was seen high.
- R2: Every falling and every rising edge lasts exactly 16 samples, whatever the plateau lengths.
- R3: A high plateau lasts `hi_len_i` samples and a low plateau lasts `lo_len_i` samples, plus any fraction carry from R6. A length of 0 is treated as 1.
- R4: Let swing = hi − lo, step = floor(swing/16) and offset = floor(fine × swing / 1024). Staircase level j (0..15) is lo + j·step + offset, limited to at most hi. Rising sample k outputs level k. Falling sample k outputs level 15−k.
- R5: During a high plateau the code equals the latched high code. During a low plateau it equals the latched low code.
- R6: A 10-bit accumulator adds `frac_i` at the start of every plateau. A carry out of bit 9 lengthens that plateau by one sample.
- R7: The high code, low code, lengths, fraction and fine index are sampled only at the edge that enters a high plateau. Changes made at other times take effect from the next high plateau.
- R8: A clock edge with enable low makes the next sample idle (segment 0) with the code equal to `lo_code_i` as sampled at that edge. It also clears the fraction accumulator, so a new run starts with zero fraction.
- R9: Under synchronous reset the segment is idle (0), the code is 0 and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low forces idle |
| hi_code_i | input | 14 | Code for the high plateau |
| lo_code_i | input | 14 | Code for the low plateau and idle |
| hi_len_i | input | 16 | High plateau length in samples |
| lo_len_i | input | 16 | Low plateau length in samples |
| frac_i | input | 10 | Fractional part of the half-period, in 1/1024 sample |
| fine_i | input | 10 | Fine-timing index for the level offset |
| code_o | output | 14 | DAC sample code |
| seg_o | output | 3 | Current segment (0 idle, 1 high, 2 fall, 3 low, 4 rise) |

## Verification
The checkers assume that the high code is always above the low code. If it were not, the swing would wrap and the monotonic-edge properties would have no meaning. Every stimulus vector keeps hi above lo, including the full-scale case. The checkers also assume that inputs change only between clock edges. The bench drives every input at the falling clock edge and samples the outputs there as well. Each run starts from idle, so the plateau lengths and fraction carries the bench expects are counted from a cleared accumulator.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int unsigned CODE_W   = 14;
    localparam int unsigned LEN_W    = 16;
    localparam int unsigned FRAC_W   = 10;
    localparam int unsigned FINE_W   = 10;
    localparam int unsigned EDGE_LOG = 4;
    localparam int unsigned EDGE_N   = 1 << EDGE_LOG;
    localparam int unsigned CNT_W    = LEN_W + 1;
    localparam int unsigned PROD_W   = CODE_W + FINE_W;
    localparam int unsigned LVL_W    = CODE_W + 2;

    typedef logic [CODE_W-1:0]   code_t;
    typedef logic [LEN_W-1:0]    len_t;
    typedef logic [FRAC_W-1:0]   frac_t;
    typedef logic [FINE_W-1:0]   fine_t;
    typedef logic [CNT_W-1:0]    cnt_t;
    typedef logic [EDGE_LOG-1:0] idx_t;

    typedef enum logic [2:0] {
        SEG_IDLE = 3'd0,
        SEG_HIGH = 3'd1,
        SEG_FALL = 3'd2,
        SEG_LOW  = 3'd3,
        SEG_RISE = 3'd4
    } seg_t;

    // Settings captured at high-plateau entry, with derived step and offset
    typedef struct packed {
        code_t hi;
        code_t lo;
        code_t step;
        code_t off;
        len_t  lo_len;
        frac_t frac;
    } cfg_t;

    function automatic cfg_t make_cfg(input code_t hi, input code_t lo,
                                      input len_t lo_len, input frac_t frac,
                                      input fine_t fine);
        cfg_t c;
        code_t swing;
        logic [PROD_W-1:0] prod;
        swing    = hi - lo;
        prod     = PROD_W'(fine) * PROD_W'(swing);
        c.hi     = hi;
        c.lo     = lo;
        c.step   = swing >> EDGE_LOG;
        c.off    = code_t'(prod >> FINE_W);
        c.lo_len = lo_len;
        c.frac   = frac;
        return c;
    endfunction

    // Plateau length with zero promoted to one sample
    function automatic cnt_t eff_len(input len_t len);
        return (len == '0) ? cnt_t'(1) : cnt_t'(len);
    endfunction

endpackage

// File: rtl/trap_cfg_reg.sv
module trap_cfg_reg
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t d,
    output cfg_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/trap_frac_acc.sv
module trap_frac_acc
    import trap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  add,
    input  frac_t frac,
    output logic  carry
);

    frac_t acc_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, frac};
        carry = sum[FRAC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (add) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic carry,
    input  len_t hi_len_new,
    input  len_t lo_len_cur,
    output seg_t seg,
    output cnt_t cnt,
    output logic enter_high,
    output logic enter_low
);

    localparam cnt_t EDGE_LAST = cnt_t'(EDGE_N - 1);

    seg_t seg_d;
    cnt_t cnt_d;

    always_comb begin
        enter_high = en && ((seg == SEG_IDLE) ||
                            (seg == SEG_RISE && cnt == EDGE_LAST));
        enter_low  = en && (seg == SEG_FALL) && (cnt == EDGE_LAST);
    end

    always_comb begin
        seg_d = seg;
        cnt_d = cnt;
        if (!en) begin
            seg_d = SEG_IDLE;
            cnt_d = '0;
        end else if (enter_high) begin
            seg_d = SEG_HIGH;
            cnt_d = eff_len(hi_len_new) + cnt_t'(carry) - cnt_t'(1);
        end else if (enter_low) begin
            seg_d = SEG_LOW;
            cnt_d = eff_len(lo_len_cur) + cnt_t'(carry) - cnt_t'(1);
        end else begin
            unique case (seg)
                SEG_HIGH, SEG_LOW: begin
                    if (cnt == '0) begin
                        seg_d = (seg == SEG_HIGH) ? SEG_FALL : SEG_RISE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt - cnt_t'(1);
                    end
                end
                SEG_FALL, SEG_RISE: cnt_d = cnt + cnt_t'(1);
                default: begin
                    seg_d = SEG_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg <= SEG_IDLE;
            cnt <= '0;
        end else begin
            seg <= seg_d;
            cnt <= cnt_d;
        end
    end

endmodule

// File: rtl/trap_level_gen.sv
module trap_level_gen
    import trap_pkg::*;
(
    input  cfg_t  cfg,
    input  idx_t  idx,
    output code_t level
);

    code_t lvl [EDGE_N];

    for (genvar j = 0; j < EDGE_N; j++) begin : g_lvl
        localparam logic [LVL_W-1:0] JW = LVL_W'(j);
        logic [LVL_W-1:0] raw;
        always_comb begin
            raw = LVL_W'(cfg.lo) + JW * LVL_W'(cfg.step) + LVL_W'(cfg.off);
            lvl[j] = (raw > LVL_W'(cfg.hi)) ? cfg.hi : code_t'(raw);
        end
    end

    assign level = lvl[idx];

endmodule

// File: rtl/trapezoid_edge_gen.sv
module trapezoid_edge_gen
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [CODE_W-1:0] hi_code_i,
    input  logic [CODE_W-1:0] lo_code_i,
    input  logic [LEN_W-1:0]  hi_len_i,
    input  logic [LEN_W-1:0]  lo_len_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [CODE_W-1:0] code_o,
    output logic [2:0]        seg_o
);

    cfg_t  cfg_new;
    cfg_t  cfg_q;
    seg_t  seg;
    cnt_t  cnt;
    logic  enter_high;
    logic  enter_low;
    logic  carry;
    logic  cfg_load;
    logic  acc_add;
    frac_t frac_sel;
    idx_t  lvl_idx;
    code_t level;

    always_comb begin
        cfg_new  = make_cfg(hi_code_i, lo_code_i, lo_len_i, frac_i, fine_i);
        cfg_load = enter_high || !en_i;
        acc_add  = enter_high || enter_low;
        frac_sel = enter_high ? frac_i : cfg_q.frac;
    end

    trap_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .d    (cfg_new),
        .q    (cfg_q)
    );

    trap_frac_acc u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (!en_i),
        .add   (acc_add),
        .frac  (frac_sel),
        .carry (carry)
    );

    trap_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en_i),
        .carry      (carry),
        .hi_len_new (hi_len_i),
        .lo_len_cur (cfg_q.lo_len),
        .seg        (seg),
        .cnt        (cnt),
        .enter_high (enter_high),
        .enter_low  (enter_low)
    );

    always_comb begin
        if (seg == SEG_FALL) begin
            lvl_idx = idx_t'(EDGE_N - 1) - cnt[EDGE_LOG-1:0];
        end else begin
            lvl_idx = cnt[EDGE_LOG-1:0];
        end
    end

    trap_level_gen u_lvl (
        .cfg   (cfg_q),
        .idx   (lvl_idx),
        .level (level)
    );

    always_comb begin
        unique case (seg)
            SEG_HIGH:           code_o = cfg_q.hi;
            SEG_FALL, SEG_RISE: code_o = level;
            default:            code_o = cfg_q.lo;
        endcase
        seg_o = seg;
    end

endmodule

// File: rtl/trap_seq_checks.sv
module trap_seq_checks
    import trap_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              en_i,
    input logic [CODE_W-1:0] hi_code_i,
    input logic [CODE_W-1:0] lo_code_i,
    input logic [CODE_W-1:0] code_o,
    input logic [2:0]        seg_o
);

    logic [2:0] last_seg;
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_seg <= SEG_IDLE;
            run_len  <= 0;
        end else begin
            last_seg <= seg_o;
            run_len  <= (seg_o == last_seg) ? run_len + 1 : 1;
        end
    end

    // R1: only legal segment successions
    a_r1_order: assert property (@(posedge clk) disable iff (rst)
        (seg_o != $past(seg_o)) |->
            (seg_o == SEG_IDLE) ||
            ($past(seg_o) == SEG_IDLE && seg_o == SEG_HIGH) ||
            ($past(seg_o) == SEG_HIGH && seg_o == SEG_FALL) ||
            ($past(seg_o) == SEG_FALL && seg_o == SEG_LOW)  ||
            ($past(seg_o) == SEG_LOW  && seg_o == SEG_RISE) ||
            ($past(seg_o) == SEG_RISE && seg_o == SEG_HIGH));

    // R2: a completed edge spans sixteen samples
    a_r2_edge_len: assert property (@(posedge clk) disable iff (rst)
        (((last_seg == SEG_FALL) || (last_seg == SEG_RISE)) &&
         (seg_o != last_seg) && (seg_o != SEG_IDLE)) |-> (run_len == EDGE_N));

    // R4: rising staircase never steps down
    a_r4_rise_mono: assert property (@(posedge clk) disable iff (rst)
        (seg_o == SEG_RISE && $past(seg_o) == SEG_RISE) |-> (code_o >= $past(code_o)));

    // R4: falling staircase never steps up
    a_r4_fall_mono: assert property (@(posedge clk) disable iff (rst)
        (seg_o == SEG_FALL && $past(seg_o) == SEG_FALL) |-> (code_o <= $past(code_o)));

    // R5: plateau codes stay constant
    a_r5_plateau_flat: assert property (@(posedge clk) disable iff (rst)
        ((seg_o == SEG_HIGH || seg_o == SEG_LOW) && seg_o == $past(seg_o))
            |-> $stable(code_o));

    // R7: high plateau entry shows the high code sampled at that edge
    a_r7_latch_hi: assert property (@(posedge clk) disable iff (rst)
        (seg_o == SEG_HIGH && $past(seg_o) != SEG_HIGH && !$past(rst))
            |-> (code_o == $past(hi_code_i)));

    // R8: disabled cycle yields idle at the low code
    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!$past(en_i) && !$past(rst))
            |-> (seg_o == SEG_IDLE && code_o == $past(lo_code_i)));

endmodule

bind trapezoid_edge_gen trap_seq_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .hi_code_i (hi_code_i),
    .lo_code_i (lo_code_i),
    .code_o    (code_o),
    .seg_o     (seg_o)
);

// File: tb/trapezoid_edge_gen_test.sv
`timescale 1ns/1ps
module trapezoid_edge_gen_test;

    localparam int NS = 160;
    localparam int NV = 6;
    // lo, hi, hl, ll, frac, fine, eh1, el1, eh2, el2, r0, r15
    localparam int TBL [NV][12] = '{
        '{1000,  9000, 4, 5,    0,    0, 4, 5, 4, 5, 1000,  8500},
        '{   0, 16383, 1, 1,  512,    0, 1, 2, 1, 2,    0, 15345},
        '{2000, 10000, 3, 3,    0,   10, 3, 3, 3, 3, 2078,  9578},
        '{ 100,  4196, 2, 2,    0, 1023, 2, 2, 2, 2, 4192,  4196},
        '{ 500,  1500, 0, 0,    0,    0, 1, 1, 1, 1,  500,  1430},
        '{   0,  1600, 6, 2, 1023,  512, 6, 3, 7, 3,  800,  1600}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [13:0] hi  = '0;
    logic [13:0] lo  = '0;
    logic [15:0] hl  = '0;
    logic [15:0] ll  = '0;
    logic [9:0]  fr  = '0;
    logic [9:0]  fn  = '0;
    logic [13:0] code;
    logic [2:0]  seg;

    int total = 0;
    int fails = 0;

    int cs [NS];
    int cc [NS];
    int rseg [16];
    int rlen [16];
    int rstart [16];
    int nr;

    always #2.5 clk = ~clk;

    trapezoid_edge_gen uut (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en),
        .hi_code_i (hi),
        .lo_code_i (lo),
        .hi_len_i  (hl),
        .lo_len_i  (ll),
        .frac_i    (fr),
        .fine_i    (fn),
        .code_o    (code),
        .seg_o     (seg)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int l, input int h, input int a, input int b,
                          input int f, input int n);
        lo = 14'(l); hi = 14'(h); hl = 16'(a); ll = 16'(b); fr = 10'(f); fn = 10'(n);
    endtask

    task automatic capture();
        en = 1'b1;
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            cs[i] = int'(seg);
            cc[i] = int'(code);
        end
    endtask

    task automatic stop_run();
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic analyze();
        nr = 0;
        for (int i = 0; i < NS; i++) begin
            if (i == 0 || cs[i] != cs[i-1]) begin
                if (nr < 16) begin
                    rseg[nr] = cs[i];
                    rlen[nr] = 1;
                    rstart[nr] = i;
                end
                nr++;
            end else if (nr <= 16) begin
                rlen[nr-1]++;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        lo = 14'd321;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset seg", int'(seg), 0);
        chk("R9 reset code", int'(code), 0);
        rst = 1'b0;
        @(negedge clk);
        // R8: idle follows the low code input
        chk("R8 idle code", int'(code), 321);
        chk("R8 idle seg", int'(seg), 0);

        for (int v = 0; v < NV; v++) begin
            setcfg(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5]);
            capture();
            stop_run();
            analyze();
            for (int k = 0; k < 8; k++) chk("R1 segment order", rseg[k], (k % 4) + 1);
            chk("R2 fall length", rlen[1], 16);
            chk("R2 rise length", rlen[3], 16);
            chk("R2 second fall length", rlen[5], 16);
            chk("R3 R6 first high", rlen[0], TBL[v][6]);
            chk("R3 R6 first low", rlen[2], TBL[v][7]);
            chk("R3 R6 second high", rlen[4], TBL[v][8]);
            chk("R3 R6 second low", rlen[6], TBL[v][9]);
            chk("R4 rise first", cc[rstart[3]], TBL[v][10]);
            chk("R4 rise last", cc[rstart[3] + 15], TBL[v][11]);
            chk("R4 fall first", cc[rstart[1]], TBL[v][11]);
            chk("R4 fall last", cc[rstart[1] + 15], TBL[v][10]);
            chk("R5 high code", cc[0], TBL[v][1]);
            chk("R1 first sample high", cs[0], 1);
            chk("R5 low code start", cc[rstart[2]], TBL[v][0]);
            chk("R5 low code end", cc[rstart[2] + rlen[2] - 1], TBL[v][0]);
        end

        // R7: mid-plateau changes wait for the next high plateau
        setcfg(1000, 9000, 10, 10, 0, 0);
        en = 1'b1;
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            cs[i] = int'(seg);
            cc[i] = int'(code);
            if (i == 3) begin
                hi = 14'd5000;
                hl = 16'd2;
            end
        end
        analyze();
        chk("R7 old high length", rlen[0], 10);
        chk("R7 old fall first", cc[rstart[1]], 8500);
        chk("R7 new high length", rlen[4], 2);
        chk("R7 new high code", cc[rstart[4]], 5000);
        chk("R7 new fall first", cc[rstart[5]], 4750);

        // R8: disable gives idle at the present low code
        lo = 14'd777;
        stop_run();
        chk("R8 disable seg", int'(seg), 0);
        chk("R8 disable code", int'(code), 777);

        // R8: accumulator is cleared by disable
        setcfg(0, 1600, 6, 2, 1023, 512);
        capture();
        stop_run();
        capture();
        stop_run();
        analyze();
        chk("R8 accumulator cleared", rlen[0], 6);
        chk("R6 carry after clear", rlen[2], 3);

        summary();
        $finish;
    end

endmodule